// File: doc/BRIEF.md
# Credit-Based Multi-Lane Link Sender

This block feeds one shared link from several per-lane (virtual channel) input queues. Each lane has a credit counter at the sender. The counter tracks how many free slots the matching downstream buffer still has. After reset every counter holds the full buffer depth. Sending a flit on a lane spends one of that lane's credits. A pulse on that lane's credit-return line gives one credit back.

In each cycle the block finds the lanes that are eligible: a lane is eligible when its queue presents a flit and its counter is not zero. A round-robin arbiter then picks exactly one eligible lane. The block pops that lane's queue head in the same cycle. On the next clock edge it drives the flit onto the link as a single valid bit, a binary lane index and the data word. If no lane is eligible, nothing is popped and the link is idle in the following cycle. A credit return that would raise a counter above the buffer depth is dropped, and the block flags it as an error.

The style of this project normally centres on a state machine. This block has no sequencing that needs one, so the design is built from per-lane counters, an arbiter and an output register.

Top module: `vc_link_sender`

## Requirements
- R1: After reset, `link_valid` and `credit_err` are 0, and every lane holds `BUF_DEPTH` credits. This is visible because each lane can send exactly `BUF_DEPTH` flits before any credit is returned.
- R2: A lane whose credit count is zero is never granted, even while its `q_valid` bit is high.
- R3: At most one lane is granted per cycle. The flit popped from lane i in cycle t appears in cycle t+1 with `link_valid`=1, `link_vc`=i (binary index) and `link_data` equal to lane i's slice `q_flit[i*DATA_W +: DATA_W]`.
- R4: Each flit sent on lane i lowers lane i's credit count by one.
- R5: Each cycle with `crd_ret[i]`=1 raises lane i's credit count by one.
- R6: When lane i sends a flit and returns a credit in the same cycle, its credit count stays the same.
- R7: Arbitration is round robin. The search starts at the lane just after the last granted lane (lane 0 after reset), wraps around after lane `NUM_VC`-1, and grants the first eligible lane it finds.
- R8: A credit count never goes above `BUF_DEPTH`. A return arriving on a full lane that is not sending in that cycle is dropped, and `credit_err` is 1 in the next cycle.
- R9: When no lane is eligible, `link_valid` is 0 in the next cycle and no counter changes, except for credits returned in that cycle.
- R10: `q_pop` is one-hot or zero. Its bit i is set only for the granted lane, in the same cycle as the grant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| q_valid | input | NUM_VC | Queue i presents a flit |
| q_flit | input | NUM_VC*DATA_W | Head flits of all queues; lane i occupies bits i*DATA_W upward |
| q_pop | output | NUM_VC | Pops the head of the granted queue |
| crd_ret | input | NUM_VC | One-credit return pulse per lane |
| link_valid | output | 1 | A flit is on the link |
| link_vc | output | VC_W | Binary index of the lane carrying the flit |
| link_data | output | DATA_W | Flit payload |
| credit_err | output | 1 | A credit return was dropped because the lane was full |

## Verification
The bench drives a single lane with no returns, so credits run out and the lane stalls. It then drives a single lane that sends and returns in every cycle, to separate a counter that holds steady from one that drifts. It also drives all lanes valid, and a sparse two-lane pattern, while credits are returned. These show whether the grant order rotates from the last winner or restarts at lane 0. Finally, surplus returns on a full lane show whether saturation and the error flag work, and a follow-up burst shows that the count did not rise above the buffer depth.

// File: rtl/vcl_pkg.sv
package vcl_pkg;
    parameter int unsigned DEF_NUM_VC    = 4;
    parameter int unsigned DEF_DATA_W    = 16;
    parameter int unsigned DEF_BUF_DEPTH = 4;

    function automatic int unsigned idx_width(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction
endpackage

// File: rtl/vcl_credit_slot.sv
module vcl_credit_slot #(
    parameter int unsigned DEPTH = 4,
    parameter int unsigned CNT_W = $clog2(DEPTH + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic take,
    input  logic give,
    output logic has_credit,
    output logic ovf
);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= FULL;
        end else begin
            unique case ({take, give})
                2'b10:   cnt <= cnt - 1'b1;
                2'b01:   if (cnt != FULL) cnt <= cnt + 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end

    always_comb begin
        has_credit = (cnt != '0);
        ovf        = give && !take && (cnt == FULL);
    end

    // R8
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= FULL);
    // R2
    take_needs_credit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> (cnt != '0));
    // R4
    take_decrements_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !give) |=> (cnt == $past(cnt) - 1'b1));
    // R6
    take_give_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (take && give) |=> $stable(cnt));
endmodule

// File: rtl/vcl_rr_arb.sv
module vcl_rr_arb #(
    parameter int unsigned N     = 4,
    parameter int unsigned IDX_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N-1:0]     req,
    output logic [N-1:0]     gnt,
    output logic [IDX_W-1:0] gnt_idx,
    output logic             any
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(N - 1);

    logic [IDX_W-1:0] ptr;

    always_comb begin
        gnt     = '0;
        gnt_idx = '0;
        any     = 1'b0;
        for (int k = 0; k < int'(N); k++) begin
            int idx;
            idx = (int'(ptr) + k) % int'(N);
            if (!any && req[idx]) begin
                any      = 1'b1;
                gnt[idx] = 1'b1;
                gnt_idx  = IDX_W'(idx);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr <= '0;
        end else if (any) begin
            ptr <= (gnt_idx == LAST) ? '0 : gnt_idx + 1'b1;
        end
    end

    // R10
    gnt_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt));
    // R2
    gnt_has_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt & ~req) == '0);
    // R9
    idle_when_no_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req == '0) |-> !any);
endmodule

// File: rtl/vc_link_sender.sv
module vc_link_sender
    import vcl_pkg::*;
#(
    parameter int unsigned NUM_VC    = DEF_NUM_VC,
    parameter int unsigned DATA_W    = DEF_DATA_W,
    parameter int unsigned BUF_DEPTH = DEF_BUF_DEPTH,
    localparam int unsigned VC_W     = idx_width(NUM_VC)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NUM_VC-1:0]        q_valid,
    input  logic [NUM_VC*DATA_W-1:0] q_flit,
    output logic [NUM_VC-1:0]        q_pop,
    input  logic [NUM_VC-1:0]        crd_ret,
    output logic                     link_valid,
    output logic [VC_W-1:0]          link_vc,
    output logic [DATA_W-1:0]        link_data,
    output logic                     credit_err
);
    localparam int unsigned CNT_W = $clog2(BUF_DEPTH + 1);

    logic [NUM_VC-1:0] has_credit;
    logic [NUM_VC-1:0] ovf;
    logic [NUM_VC-1:0] eligible;
    logic [NUM_VC-1:0] gnt;
    logic [VC_W-1:0]   gnt_idx;
    logic              gnt_any;
    logic [DATA_W-1:0] sel_flit;

    for (genvar v = 0; v < int'(NUM_VC); v++) begin : g_lane
        vcl_credit_slot #(
            .DEPTH (BUF_DEPTH),
            .CNT_W (CNT_W)
        ) u_slot (
            .clk        (clk),
            .rst_n      (rst_n),
            .take       (gnt[v]),
            .give       (crd_ret[v]),
            .has_credit (has_credit[v]),
            .ovf        (ovf[v])
        );
    end

    always_comb eligible = q_valid & has_credit;

    vcl_rr_arb #(
        .N     (NUM_VC),
        .IDX_W (VC_W)
    ) u_arb (
        .clk     (clk),
        .rst_n   (rst_n),
        .req     (eligible),
        .gnt     (gnt),
        .gnt_idx (gnt_idx),
        .any     (gnt_any)
    );

    always_comb begin
        q_pop    = gnt;
        sel_flit = q_flit[int'(gnt_idx)*DATA_W +: DATA_W];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            link_valid <= 1'b0;
            link_vc    <= '0;
            link_data  <= '0;
            credit_err <= 1'b0;
        end else begin
            link_valid <= gnt_any;
            credit_err <= |ovf;
            if (gnt_any) begin
                link_vc   <= gnt_idx;
                link_data <= sel_flit;
            end
        end
    end

    // R3
    pop_then_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q_pop != '0) |=> link_valid);
    // R9
    no_pop_then_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q_pop == '0) |=> !link_valid);
    // R10
    pop_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q_pop & ~q_valid) == '0);
endmodule

// File: tb/vc_link_sender_tb.sv
module vc_link_sender_tb;
    localparam int NV = 4;
    localparam int DW = 16;
    localparam int DEPTH = 4;
    localparam int VW = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NV-1:0]    q_valid = '0;
    logic [NV*DW-1:0] q_flit = '0;
    logic [NV-1:0]    q_pop;
    logic [NV-1:0]    crd_ret = '0;
    logic             link_valid;
    logic [VW-1:0]    link_vc;
    logic [DW-1:0]    link_data;
    logic             credit_err;

    always #2 clk = ~clk;

    vc_link_sender #(.NUM_VC(NV), .DATA_W(DW), .BUF_DEPTH(DEPTH)) u_dut (
        .clk(clk), .rst_n(rst_n), .q_valid(q_valid), .q_flit(q_flit),
        .q_pop(q_pop), .crd_ret(crd_ret), .link_valid(link_valid),
        .link_vc(link_vc), .link_data(link_data), .credit_err(credit_err)
    );

    typedef struct {
        logic          v;
        logic [VW-1:0] vc;
        logic [DW-1:0] data;
        logic          err;
        string         tag;
    } exp_t;

    exp_t exp_q[$];
    int checks = 0;
    int failures = 0;
    int mcred[NV];
    int seq[NV];
    int ptr = 0;
    bit done = 0;

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int expv);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, expv);
        end
    endtask

    task automatic step(input logic [NV-1:0] vm, input logic [NV-1:0] rm,
                        input string tag);
        int g;
        logic [NV-1:0] exp_pop;
        exp_t e;
        @(negedge clk);
        q_valid = vm;
        crd_ret = rm;
        for (int v = 0; v < NV; v++) q_flit[v*DW +: DW] = {4'(v), 12'(seq[v])};
        #1;
        g = -1;
        for (int k = 0; k < NV; k++) begin
            int idx;
            idx = (ptr + k) % NV;
            if (g < 0 && vm[idx] && mcred[idx] > 0) g = idx;
        end
        exp_pop = '0;
        if (g >= 0) exp_pop[g] = 1'b1;
        chk(q_pop == exp_pop, {tag, "/R10"}, "q_pop", int'(q_pop), int'(exp_pop));
        e.v = (g >= 0);
        e.vc = (g >= 0) ? VW'(g) : '0;
        e.data = (g >= 0) ? {4'(g), 12'(seq[g])} : '0;
        e.err = 1'b0;
        e.tag = tag;
        for (int v = 0; v < NV; v++) begin
            bit sent;
            sent = (v == g);
            if (rm[v] && !sent && mcred[v] == DEPTH) e.err = 1'b1;
            if (sent && !rm[v]) mcred[v]--;
            else if (!sent && rm[v] && mcred[v] < DEPTH) mcred[v]++;
        end
        if (g >= 0) begin
            seq[g]++;
            ptr = (g + 1) % NV;
        end
        exp_q.push_back(e);
    endtask

    initial begin : monitor
        forever begin
            @(posedge clk);
            #1;
            if (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                chk(link_valid == e.v, {e.tag, "/R3"}, "link_valid", int'(link_valid), int'(e.v));
                if (e.v) begin
                    chk(link_vc == e.vc, {e.tag, "/R3"}, "link_vc", int'(link_vc), int'(e.vc));
                    chk(link_data == e.data, {e.tag, "/R3"}, "link_data", int'(link_data), int'(e.data));
                end
                chk(credit_err == e.err, {e.tag, "/R8"}, "credit_err", int'(credit_err), int'(e.err));
            end
        end
    end

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin : driver
        for (int v = 0; v < NV; v++) begin
            mcred[v] = DEPTH;
            seq[v] = 0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        // R1 reset state
        chk(link_valid == 1'b0, "R1", "link_valid", int'(link_valid), 0);
        chk(credit_err == 1'b0, "R1", "credit_err", int'(credit_err), 0);
        chk(q_pop == '0, "R1", "q_pop", int'(q_pop), 0);
        // R1/R4: exactly DEPTH flits leave lane 0
        repeat (DEPTH) step(4'b0001, 4'b0000, "R4");
        // R2: lane 0 out of credits, stays valid, no grant
        repeat (2) step(4'b0001, 4'b0000, "R2");
        // R5: two returns then two flits go and one stalls
        repeat (2) step(4'b0000, 4'b0001, "R5");
        repeat (3) step(4'b0001, 4'b0000, "R5");
        // R6: send and return together keeps lane 1 going indefinitely
        repeat (10) step(4'b0010, 4'b0010, "R6");
        // R7: rotation with all lanes requesting, then a sparse pattern
        repeat (8) step(4'b1111, 4'b1111, "R7");
        repeat (4) step(4'b0101, 4'b0101, "R7");
        step(4'b1000, 4'b0000, "R7");
        repeat (3) step(4'b1011, 4'b0000, "R7");
        // refill every lane
        repeat (DEPTH + 1) step(4'b0000, 4'b1111, "R5");
        // R8: surplus returns on a full lane, then only DEPTH flits go
        repeat (2) step(4'b0000, 4'b0100, "R8");
        repeat (DEPTH + 2) step(4'b0100, 4'b0000, "R8");
        // R9: nothing eligible
        repeat (3) step(4'b0000, 4'b0000, "R9");
        step(4'b0100, 4'b0000, "R9");
        repeat (3) begin
            @(negedge clk);
            q_valid = '0;
            crd_ret = '0;
        end
        repeat (2) @(posedge clk);
        #2;
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule